// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the unsigned product of two operands of equal width by repeated add-and-shift, spending one clock per operand bit and using a single adder the width of one operand. A one-cycle start pulse presents both operands. The block takes them in, clears its product registers and then runs one iteration per cycle. In each iteration the lowest remaining bit of the multiplier decides whether the multiplicand or zero is added to the upper half of the running product. After the last iteration a one-cycle done pulse marks the double-width product as valid.

The running product is held in two pieces. The upper piece is one bit wider than an operand, so that it can keep the adder's carry-out. The lower piece is a shift register one bit narrower than an operand, which collects each product bit once no later addition can change it. The product output is the concatenation of the two pieces. It keeps its value after done until another start is accepted. A start that arrives while a multiplication is running is ignored.

Top module: `shift_add_mul`

## Requirements
- R1: When a start is accepted with operands a and b, the product output equals the unsigned value a*b, zero-extended to 2*WIDTH bits, in the cycle in which done is high.
- R2: If start is sampled high at a rising edge while the block is idle, done is high for exactly one cycle: the cycle that follows the WIDTH-th rising edge after that one. done is low in every other cycle.
- R3: A start that is high while a multiplication is running is ignored. The operands it carries do not affect the result, and the timing of done is unchanged.
- R4: The product output keeps its value from the done cycle until a start is accepted. At the rising edge that accepts a start, the product output becomes zero.
- R5: While the synchronous active-high reset is sampled high, the block returns to idle, done goes low and the product output goes to zero.
- R6: Operand values at the extremes give exact results. With both operands at all ones (WIDTH=16) the product is 0xFFFE0001, which uses the carry-out of the adder. With either operand zero the product is zero.
- R7: A start that is high in the same cycle as done is accepted, because the block is idle in that cycle. Its done pulse follows after WIDTH further edges, per R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; sampled only while the block is idle |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Concatenation of the upper accumulator and the low-bit shift register |

## Verification
The bench builds the block with its default WIDTH of 16. At this width the all-ones operand pair drives a carry out of the adder into the top bit of the upper register. The 15-bit low register is filled exactly once per run, so a miscounted iteration shows up as a wrong product. A behavioural model counts cycles from each accepted start and predicts done and the product on every clock. This lets the bench observe a start that arrives mid-run, a start that arrives in the done cycle, and long idle gaps in which the product must hold.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int DEF_WIDTH = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    // control strobes the sequencer hands to the datapath
    typedef struct packed {
        logic load;   // capture operands, clear product pieces
        logic step;   // one add-and-shift iteration
    } mul_ctl_t;

    // counter width able to hold 0 .. w
    function automatic int cnt_bits(input int w);
        return $clog2(w) + 1;
    endfunction

endpackage

// File: rtl/mul_shreg.sv
module mul_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic         ser_in,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (load_en)
            q_r <= d;
        else if (shift_en)
            q_r <= {ser_in, q_r[W-1:1]};
    end

    assign q = q_r;

    // R1: a shift step moves the stored word one place toward bit 0
    p_shift_moves_r1: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en) |=> (q_r[W-2:0] == $past(q_r[W-1:1])));

endmodule

// File: rtl/mul_upper.sv
module mul_upper #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         sel_bit,
    input  logic [W-1:0] mcand,
    output logic [W:0]   q
);
    logic [W:0]   q_r;
    logic [W-1:0] addend;
    logic [W:0]   sum;

    assign addend = sel_bit ? mcand : '0;
    assign sum    = {1'b0, q_r[W:1]} + {1'b0, addend};

    always_ff @(posedge clk) begin
        if (rst || clr)
            q_r <= '0;
        else if (en)
            q_r <= sum;
    end

    assign q = q_r;

    // R4: a clear leaves the upper accumulator at zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q_r == '0));

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output mul_ctl_t ctl,
    output logic     done
);
    localparam int CW = cnt_bits(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e    state;
    logic [CW-1:0] cnt;
    logic          done_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state  <= ST_IDLE;
                        done_r <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ctl.load = (state == ST_IDLE) && start;
    assign ctl.step = (state == ST_RUN);
    assign done     = done_r;

    // R2: done never lasts two cycles
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_r |=> !done_r);

    // R3: a start in the middle of a run does not end or restart it
    p_start_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cnt != LAST && start) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    localparam int LOW_W = WIDTH - 1;

    mul_ctl_t         ctl;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [WIDTH:0]   upper_q;
    logic [LOW_W-1:0] low_q;

    mul_ctrl #(.W(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .done  (done)
    );

    // multiplicand: load only, never shifts
    mul_shreg #(.W(WIDTH)) u_mcand (
        .clk      (clk),
        .rst      (rst),
        .load_en  (ctl.load),
        .shift_en (1'b0),
        .ser_in   (1'b0),
        .d        (op_a),
        .q        (mcand_q)
    );

    // multiplier: loaded, then one bit consumed per step
    mul_shreg #(.W(WIDTH)) u_mplier (
        .clk      (clk),
        .rst      (rst),
        .load_en  (ctl.load),
        .shift_en (ctl.step),
        .ser_in   (1'b0),
        .d        (op_b),
        .q        (mplier_q)
    );

    mul_upper #(.W(WIDTH)) u_upper (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.load),
        .en      (ctl.step),
        .sel_bit (mplier_q[0]),
        .mcand   (mcand_q),
        .q       (upper_q)
    );

    // settled low bits: cleared by a load of zero, fed from the upper lsb
    mul_shreg #(.W(LOW_W)) u_low (
        .clk      (clk),
        .rst      (rst),
        .load_en  (ctl.load),
        .shift_en (ctl.step),
        .ser_in   (upper_q[0]),
        .d        ('0),
        .q        (low_q)
    );

    assign product = {upper_q, low_q};

    // R4: with no load and no step the product output does not move
    p_product_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.step) |=> $stable(product));

    // R4: an accepted start zeroes the product at the same edge
    p_product_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (product == '0));

endmodule

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string case_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    shift_add_mul #(.WIDTH(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .done    (done),
        .product (product)
    );

    // behavioural reference: busy flag, countdown, latched operands
    bit          m_busy = 0;
    int          m_left = 0;
    bit          m_done = 0;
    bit          m_known = 1;
    longint      m_prod = 0;
    longint      m_a = 0;
    longint      m_b = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_left = 0; m_done = 0; m_known = 1; m_prod = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_known = 1;
                    m_prod = (m_a * m_b) & 64'hFFFF_FFFF;
                end
            end else if (start) begin
                m_busy = 1; m_left = W; m_a = op_a; m_b = op_b;
                m_known = 0; m_prod = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R2 done (%s) actual=%0b expected=%0b t=%0t", case_tag, done, m_done, $time);
            end
            if (m_known) begin
                checks++;
                if (product !== m_prod[2*W-1:0]) begin
                    errors++;
                    if (m_done)
                        $display("FAIL R1 product (%s) actual=%h expected=%h", case_tag, product, m_prod[2*W-1:0]);
                    else
                        $display("FAIL R4 hold (%s) actual=%h expected=%h", case_tag, product, m_prod[2*W-1:0]);
                end
            end
        end
    end

    task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4*W; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        case_tag = tag;
        pulse_start(a, b);
        wait_done();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R5: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || product !== '0) begin
            errors++;
            $display("FAIL R5 reset actual=%0b/%h expected=0/0", done, product);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_one(16'd3, 16'd5, "R1 small");
        run_one(16'h1234, 16'h00FF, "R1 mixed");
        run_one(16'hFFFF, 16'hFFFF, "R6 all ones");
        run_one(16'h0000, 16'hBEEF, "R6 zero a");
        run_one(16'hABCD, 16'h0000, "R6 zero b");
        run_one(16'hFFFF, 16'h0001, "R6 times one");
        run_one(16'h8000, 16'h8000, "R6 top bits");

        // R3: extra start in the middle of a run
        case_tag = "R3 mid-run start";
        pulse_start(16'h0102, 16'h0304);
        repeat (5) @(negedge clk);
        op_a = 16'hFFFF; op_b = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0;
        wait_done();
        repeat (2) @(negedge clk);

        // R7: start raised in the done cycle
        case_tag = "R7 back-to-back";
        pulse_start(16'h7777, 16'h0011);
        wait_done();
        op_a = 16'hC3A5; op_b = 16'h5A3C; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0;
        wait_done();

        // R4: long idle hold, with operand inputs toggling but no start
        case_tag = "R4 idle hold";
        for (int k = 0; k < 20; k++) begin
            op_a = 16'(k * 997); op_b = 16'(k * 31);
            @(negedge clk);
        end
        op_a = '0; op_b = '0;

        // R5: reset after a product is held
        case_tag = "R5 reset";
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || product !== '0) begin
            errors++;
            $display("FAIL R5 reset actual=%0b/%h expected=0/0", done, product);
        end
        rst = 1'b0;
        run_one(16'h0F0F, 16'hF0F0, "R1 after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule